// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a tiny processor that knows one operation. Each program word holds three memory addresses. The core reads the word at the program counter and uses the first address as the destination. It subtracts the word at the second address from the word at the destination and stores the difference back at the destination. If the stored difference is negative, control moves to the third address. Otherwise the next word in address order is fetched. There is no stop operation. A program parks itself on an instruction whose taken branch points at its own address.

Program and data share one external read-write memory, which the core drives over a simple bus. The bus has an access enable, a direction line, an address and write data. Read data comes back in the same cycle. Each instruction takes five clock cycles. Four of them carry one memory access each, and the fifth is idle while the program counter is updated.

Top module: `sbn_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the core presents a read (`mem_en`=1, `mem_rd_nwr`=1) of address 0.
- R2: The fetched word is split as destination a = bits [11:8], source b = bits [7:4] and target c = bits [3:0]. The second access of an instruction reads address a and the third reads address b.
- R3: The fourth access is a write (`mem_rd_nwr`=0) to address a. Its data is the earlier value at a minus the value at b, wrapped modulo 2^12.
- R4: If bit 11 of the written value is 1, the next instruction is fetched from c.
- R5: Otherwise the next fetch address is the current one plus 1, and 15 wraps to 0.
- R6: Every instruction occupies exactly five cycles: fetch, read a, read b, write a, then one cycle with `mem_en`=0. The read/write line is 0 only in the write cycle.
- R7: Consider an instruction whose target c is its own address, with the value at a negative and the value at b equal to 0. That instruction repeats forever at the same fetch address and leaves memory unchanged.
- R8: Because the instruction word is fetched before its operands are read, an instruction that overwrites its own word still completes with the operands it fetched. The fetch after it then sees the updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Memory access enable |
| mem_rd_nwr | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 4 | Memory word address, MSB first |
| mem_wdata | output | 12 | Data written to memory, MSB first |
| mem_rdata | input | 12 | Data read from memory, valid in the same cycle |

## Verification
The bench builds the core with its default parameters: 4-bit addresses, 12-bit words, and the registered-difference variant. With 4-bit addresses the whole memory fits in sixteen entries. The programs can therefore place instructions at the top address, which exercises the program-counter wrap. They can also place code and data side by side, which allows a self-modifying instruction. The 12-bit word makes the signed extremes easy to reach: subtracting 1 from the most negative value overflows to a positive result and must not branch. The alternative combinational-subtract variant is chosen by changing `REG_DIFF` on the bench instance and needs no other changes to the bench.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
   typedef enum logic [2:0] {
      ST_FETCH = 3'd0,
      ST_RDA   = 3'd1,
      ST_RDB   = 3'd2,
      ST_WRA   = 3'd3,
      ST_NEXT  = 3'd4
   } sbn_state_e;
endpackage

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
   import sbn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   output sbn_state_e state
);
   sbn_state_e state_d;

   always_comb begin
      unique case (state)
         ST_FETCH: state_d = ST_RDA;
         ST_RDA:   state_d = ST_RDB;
         ST_RDB:   state_d = ST_WRA;
         ST_WRA:   state_d = ST_NEXT;
         default:  state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= state_d;
   end
endmodule

// File: rtl/sbn_pc.sv
module sbn_pc #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              take,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc <= '0;
      else if (advance) pc <= take ? target : pc + ADDR_W'(1);
   end
endmodule

// File: rtl/sbn_datapath.sv
module sbn_datapath
   import sbn_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 12,
   parameter bit REG_DIFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sbn_state_e        state,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] fld_a,
   output logic [ADDR_W-1:0] fld_b,
   output logic [ADDR_W-1:0] fld_c,
   output logic [DATA_W-1:0] wdata,
   output logic              neg
);
   localparam int SIGN_BIT = DATA_W - 1;

   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] opa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q  <= '0;
         opa_q <= '0;
      end else begin
         if (state == ST_FETCH) ir_q  <= rdata;
         if (state == ST_RDA)   opa_q <= rdata;
      end
   end

   assign fld_a = ir_q[DATA_W-1 -: ADDR_W];
   assign fld_b = ir_q[2*ADDR_W-1 -: ADDR_W];
   assign fld_c = ir_q[ADDR_W-1:0];

   generate
      if (REG_DIFF) begin : g_reg_diff
         logic [DATA_W-1:0] diff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                diff_q <= '0;
            else if (state == ST_RDB)  diff_q <= opa_q - rdata;
         end
         assign wdata = diff_q;
      end else begin : g_comb_diff
         logic [DATA_W-1:0] opb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                opb_q <= '0;
            else if (state == ST_RDB)  opb_q <= rdata;
         end
         assign wdata = opa_q - opb_q;
      end
   endgenerate

   assign neg = wdata[SIGN_BIT];
endmodule

// File: rtl/sbn_core.sv
module sbn_core
   import sbn_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 12,
   parameter bit REG_DIFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_en,
   output logic              mem_rd_nwr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int FIELDS = 3;

   generate
      if (FIELDS * ADDR_W != DATA_W) begin : g_bad_width
         $error("sbn_core: DATA_W must hold exactly three ADDR_W fields");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("sbn_core: ADDR_W must be positive");
      end
   endgenerate

   sbn_state_e        state;
   logic [ADDR_W-1:0] pc, fld_a, fld_b, fld_c;
   logic              neg;

   sbn_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state)
   );

   sbn_datapath #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_DIFF (REG_DIFF)
   ) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .rdata (mem_rdata),
      .fld_a (fld_a),
      .fld_b (fld_b),
      .fld_c (fld_c),
      .wdata (mem_wdata),
      .neg   (neg)
   );

   sbn_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (state == ST_NEXT),
      .take    (neg),
      .target  (fld_c),
      .pc      (pc)
   );

   always_comb begin
      unique case (state)
         ST_RDA, ST_WRA: mem_addr = fld_a;
         ST_RDB:         mem_addr = fld_b;
         default:        mem_addr = pc;
      endcase
   end

   assign mem_en     = (state != ST_NEXT);
   assign mem_rd_nwr = (state != ST_WRA);
endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_en,
   input logic              mem_rd_nwr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);
   logic              prev_idle, seen, last_neg;
   logic [ADDR_W-1:0] f_pc, f_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_idle <= 1'b1;
         seen      <= 1'b0;
         last_neg  <= 1'b0;
         f_pc      <= '0;
         f_c       <= '0;
      end else begin
         prev_idle <= !mem_en;
         if (mem_en && prev_idle) begin
            f_pc <= mem_addr;
            f_c  <= mem_rdata[ADDR_W-1:0];
            seen <= 1'b1;
         end
         if (mem_en && !mem_rd_nwr) last_neg <= mem_wdata[DATA_W-1];
      end
   end

   // R6
   idle_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_rd_nwr) |=> !mem_en);

   // R6
   fetch_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en |=> (mem_en && mem_rd_nwr));

   // R3
   write_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_rd_nwr) |-> (mem_addr == $past(mem_addr, 2)));

   // R4 R5
   next_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && prev_idle && seen) |->
         (mem_addr == (last_neg ? f_c : ADDR_W'(f_pc + 1'b1))));
endmodule

bind sbn_core sbn_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sbn_core.sv
`timescale 1ns/1ps
module sim_sbn_core;
   typedef struct packed {
      logic [2:0]  kind;   // 0 fetch, 1 read a, 2 read b, 3 write a, 4 idle
      logic [3:0]  addr;
      logic [11:0] data;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_en, mem_rd_nwr;
   logic [3:0]  mem_addr;
   logic [11:0] mem_wdata, mem_rdata;
   logic [11:0] mem [16];
   logic [11:0] refm [16];
   item_t       exp_q [$];
   int          n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   sbn_core #(.ADDR_W(4), .DATA_W(12), .REG_DIFF(1'b1)) u0 (
      .clk, .rst_n, .mem_en, .mem_rd_nwr, .mem_addr, .mem_wdata, .mem_rdata
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk)
      if (rst_n && mem_en && !mem_rd_nwr) mem[mem_addr] <= mem_wdata;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // monitor: pops one expected bus cycle per clock
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         if (it.kind == 3'd4) begin
            check(mem_en == 1'b0, "R6 idle cycle", mem_en, 0);
         end else begin
            check(mem_en == 1'b1, "R6 access enable", mem_en, 1);
            check(mem_rd_nwr == (it.kind != 3'd3), "R6 direction", mem_rd_nwr, it.kind != 3'd3);
            case (it.kind)
               3'd0: check(mem_addr == it.addr, "R1 R4 R5 R7 fetch address", mem_addr, it.addr);
               3'd1, 3'd2: check(mem_addr == it.addr, "R2 operand address", mem_addr, it.addr);
               default: begin
                  check(mem_addr == it.addr, "R3 write address", mem_addr, it.addr);
                  check(mem_wdata == it.data, "R3 R8 write data", mem_wdata, it.data);
               end
            endcase
         end
      end
   end

   // driver: reference interpreter pushes the expected bus cycles
   task automatic predict(input int n_instr);
      logic [3:0] pc = 4'd0;
      for (int i = 0; i < 16; i++) refm[i] = mem[i];
      for (int k = 0; k < n_instr; k++) begin
         logic [11:0] w, d;
         logic [3:0]  a, b, c;
         w = refm[pc];
         a = w[11:8]; b = w[7:4]; c = w[3:0];
         d = refm[a] - refm[b];
         exp_q.push_back('{kind: 3'd0, addr: pc, data: 12'd0});
         exp_q.push_back('{kind: 3'd1, addr: a,  data: 12'd0});
         exp_q.push_back('{kind: 3'd2, addr: b,  data: 12'd0});
         exp_q.push_back('{kind: 3'd3, addr: a,  data: d});
         exp_q.push_back('{kind: 3'd4, addr: 4'd0, data: 12'd0});
         refm[a] = d;
         pc = d[11] ? c : pc + 4'd1;
      end
   endtask

   task automatic run_prog(input string name, input int n_instr);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset presents a read of address 0
      check(mem_en && mem_rd_nwr && mem_addr == 4'd0, {"R1 reset state ", name},
            {mem_en, mem_rd_nwr, mem_addr}, {1'b1, 1'b1, 4'd0});
      predict(n_instr);
      @(posedge clk); #1 rst_n = 1'b1;
      wait (exp_q.size() == 0);
      @(negedge clk); #1 rst_n = 1'b0;
      for (int i = 0; i < 16; i++)
         check(mem[i] == refm[i], {"R3 R7 final memory ", name}, mem[i], refm[i]);
   endtask

   initial begin
      #(200000 * 10);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      // program 1: immediate self loop (R7)
      for (int i = 0; i < 16; i++) mem[i] = 12'h000;
      mem[0] = 12'h120; mem[1] = 12'hFFF; mem[2] = 12'h000;
      run_prog("halt", 3);

      // program 2: countdown, overflow, equal operands, pc wrap (R4 R5)
      for (int i = 0; i < 16; i++) mem[i] = 12'h000;
      mem[0]  = 12'hDE3;  // counter -= 1, negative -> 3
      mem[1]  = 12'hAB5;  // 0 - (-1) positive, falls through
      mem[2]  = 12'h9E0;  // always-negative jump to 0
      mem[3]  = 12'hCE0;  // 0x800 - 1 overflows positive, falls through
      mem[4]  = 12'h9EF;  // jump to 15
      mem[15] = 12'hAA3;  // x - x = 0, falls through and wraps to 0
      mem[9]  = 12'h000; mem[10] = 12'h000; mem[11] = 12'hFFF;
      mem[12] = 12'h800; mem[13] = 12'h003; mem[14] = 12'h001;
      run_prog("loop", 40);

      // program 3: instruction overwrites its own word (R8), then halts
      for (int i = 0; i < 16; i++) mem[i] = 12'h000;
      mem[0] = 12'h012; mem[1] = 12'h013;
      mem[2] = 12'h342; mem[3] = 12'hFFF; mem[4] = 12'h000;
      run_prog("selfmod", 4);

      summary();
   end
endmodule